// File: doc/BRIEF.md
# Prescaled Down-Counting Interval Timer

This block is a single memory-mapped interval timer. A down-counter, 16 bits wide by default, steps once per prescaled tick. The tick comes from a prescaler that passes every clock, every 16th clock or every 256th clock. Software reads the current value directly and can invert it to get an up-count.

In periodic mode the counter restarts from a held reload value once it has reached zero. In free-running mode it wraps from zero to all ones. Each time the counter steps from 1 to 0, a sticky expiry flag is set. A write of any data to the acknowledge register clears the flag. The interrupt output is the flag gated by an interrupt-enable bit, and that bit is set after reset.

The register port is a simple single-cycle write strobe with a word address. Reads are combinational from the same address.

Top module: `tick_timer`

## Requirements
- R1: After reset the counter reads 0, the reload register reads 0, the control register reads 0x0010 and `irq_o` is low.
- R2: A write to address 0 stores the reload value and also loads the counter on the same edge, whether or not the timer is running. On that edge the load takes priority over a tick.
- R3: Control register (address 2) fields: bit 0 enable, bit 1 periodic, bits 3:2 prescale select, bit 4 interrupt enable. The register reads back what was written. With select 00 and enable set, the counter steps down by one on every clock.
- R4: Select 01 steps the counter every 16 clocks; select 10 or 11 steps it every 256 clocks. The prescaler restarts when the timer is disabled, so the first step comes exactly one full period after the enabling write.
- R5: In periodic mode, a tick while the counter is 0 loads the reload value. With reload L>0 the count sequence is L, L-1, …, 0, L, …
- R6: In free-running mode (bit 1 clear), a tick while the counter is 0 gives 0xFFFF.
- R7: The expiry flag is set by a tick that moves the counter from 1 to 0. It stays set until it is cleared.
- R8: A write of any data to address 3 clears the flag. If a new expiry happens on the same edge, the flag stays set. Address 3 reads 0.
- R9: `irq_o` is the expiry flag ANDed with control bit 4.
- R10: Writing 0 to the control register stops the counter. The value holds until the timer is enabled again or reloaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Write strobe, one write per cycle |
| reg_addr | input | 2 | Word address: 0 reload, 1 counter, 2 control, 3 acknowledge |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data for `reg_addr` |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench sweeps every cycle of short runs in each prescale setting and both modes. It compares the counter and interrupt against values computed from the tick count. This catches an off-by-one prescale period, which would put every step one cycle early or late, and a missed prescaler restart, which would make the first step come early. It also probes the reload-at-zero and wrap-to-all-ones boundaries, where swapping the modes gives the wrong next value. It hits an acknowledge write on the very edge of an expiry; a design that lets the clear win would lose that interrupt. It also checks that a reload write takes effect at once while the timer is running, and that masking hides a pending flag without erasing it.

// File: rtl/tick_timer_pkg.sv
// Shared types for the interval timer: control fields, prescale codes and
// register addresses. Assumes a data path of at least 5 bits.
package tick_timer_pkg;

    typedef enum logic [1:0] {
        PS_DIV1   = 2'b00,
        PS_DIV16  = 2'b01,
        PS_DIV256 = 2'b10,
        PS_DIV256B = 2'b11
    } presc_e;

    typedef struct packed {
        logic       irq_en;    // bit 4
        presc_e     presc;     // bits 3:2
        logic       periodic;  // bit 1
        logic       enable;    // bit 0
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    localparam logic [1:0] A_RELOAD = 2'd0;
    localparam logic [1:0] A_COUNT  = 2'd1;
    localparam logic [1:0] A_CTRL   = 2'd2;
    localparam logic [1:0] A_ACK    = 2'd3;

endpackage

// File: rtl/tick_timer_prescale.sv
// Tick generator: emits one-cycle ticks every 1, 2**MID_LOG2 or 2**MAX_LOG2
// clocks while enabled. Held at zero while disabled, so the first tick after
// enabling arrives one full period later. Assumes MID_LOG2 < MAX_LOG2.
module tick_timer_prescale
    import tick_timer_pkg::*;
#(
    parameter int MID_LOG2 = 4,
    parameter int MAX_LOG2 = 8
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   en,
    input  presc_e sel,
    output logic   tick
);
    localparam int PRE_W = MAX_LOG2;
    localparam logic [PRE_W-1:0] MID_LAST = PRE_W'((1 << MID_LOG2) - 1);
    localparam logic [PRE_W-1:0] MAX_LAST = PRE_W'((1 << MAX_LOG2) - 1);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] last;

    // Pick the terminal count for the selected division.
    always_comb begin
        case (sel)
            PS_DIV1:  last = '0;
            PS_DIV16: last = MID_LAST;
            default:  last = MAX_LAST;
        endcase
    end

    assign tick = en && (pre_q >= last);

    // Advance the prescale counter; clear it on a tick or while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || tick) pre_q <= '0;
        else                       pre_q <= pre_q + 1'b1;
    end

    // R4: a disabled prescaler is held at its start point
    assert_prescale_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (pre_q == '0));

endmodule

// File: rtl/tick_timer_count.sv
// Down-counter core: a load write sets the value at once; otherwise each
// tick decrements, and at zero either reloads (periodic) or wraps to all
// ones. Reports an expiry when a tick moves the value from 1 to 0.
module tick_timer_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_we,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             tick,
    input  logic             periodic,
    output logic [CNT_W-1:0] value,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] value_q;

    assign value  = value_q;
    assign expire = tick && !load_we && (value_q == ONE);

    // Update the count: load first, then tick-driven step, reload or wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)
            value_q <= '0;
        else if (load_we)
            value_q <= load_val;
        else if (tick) begin
            if (value_q != '0)  value_q <= value_q - ONE;
            else if (periodic)  value_q <= reload_val;
            else                value_q <= '1;
        end
    end

    // R3: a tick on a nonzero count steps it down by one
    assert_step_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load_we && value_q != '0) |=> (value_q == $past(value_q) - ONE));
    // R10: with no tick and no load the count holds
    assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load_we) |=> $stable(value_q));
    // R6: free-running wrap lands on all ones
    assert_wrap_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load_we && !periodic && value_q == '0) |=> (value_q == '1));
    // R2: a load write lands in the count
    assert_load_now_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_we |=> (value_q == $past(load_val)));

endmodule

// File: rtl/tick_timer.sv
// Interval timer top: register file (reload, control, acknowledge), sticky
// expiry flag and gated interrupt. Single clock; reads are combinational.
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int MID_LOG2 = 4,
    parameter int MAX_LOG2 = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [1:0]       reg_addr,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    output logic             irq_o
);
    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] value;
    logic             tick;
    logic             expire;
    logic             flag_q;
    logic             load_we;
    logic             ack_we;

    assign load_we = reg_we && (reg_addr == A_RELOAD);
    assign ack_we  = reg_we && (reg_addr == A_ACK);

    // Hold the reload value and control fields written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
            ctrl_q   <= '{irq_en: 1'b1, presc: PS_DIV1, periodic: 1'b0, enable: 1'b0};
        end else if (reg_we) begin
            if (reg_addr == A_RELOAD) reload_q <= reg_wdata;
            if (reg_addr == A_CTRL)   ctrl_q   <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
        end
    end

    tick_timer_prescale #(.MID_LOG2(MID_LOG2), .MAX_LOG2(MAX_LOG2)) u_prescale (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (ctrl_q.enable),
        .sel  (ctrl_q.presc),
        .tick (tick)
    );

    tick_timer_count #(.CNT_W(CNT_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_we   (load_we),
        .load_val  (reg_wdata),
        .reload_val(reload_q),
        .tick      (tick),
        .periodic  (ctrl_q.periodic),
        .value     (value),
        .expire    (expire)
    );

    // Sticky expiry flag: a new expiry wins over an acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag_q <= 1'b0;
        else if (expire) flag_q <= 1'b1;
        else if (ack_we) flag_q <= 1'b0;
    end

    // Read multiplexer over the register map.
    always_comb begin
        case (reg_addr)
            A_RELOAD: reg_rdata = reload_q;
            A_COUNT:  reg_rdata = value;
            A_CTRL:   reg_rdata = CNT_W'(ctrl_q);
            default:  reg_rdata = '0;
        endcase
    end

    assign irq_o = flag_q && ctrl_q.irq_en;

    // R7: the flag only rises after an expiry
    assert_flag_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(expire));
    // R7: with no acknowledge the flag stays set
    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !ack_we) |=> flag_q);
    // R8: acknowledge without a coincident expiry clears
    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_we && !expire) |=> !flag_q);
    // R9: interrupt never fires while masked
    assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ctrl_q.irq_en);

endmodule

// File: tb/tick_timer_bench.sv
module tick_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_we;
    logic [1:0]  reg_addr;
    logic [15:0] reg_wdata;
    logic [15:0] reg_rdata;
    logic        irq_o;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    tick_timer u_tick_timer (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Write at a negedge; returns at the next negedge after the capturing edge.
    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = 2'd1; reg_wdata = 16'h0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        reg_addr = a;
        #1;
        v = int'(reg_rdata);
        reg_addr = 2'd1;
    endtask

    task automatic setup(input logic [15:0] load);
        wr(2'd2, 16'h0000);
        wr(2'd0, load);
        wr(2'd3, 16'h1234);
    endtask

    // Run one configuration and check count and irq on every cycle up to nmax.
    task automatic sweep(input string req, input logic [1:0] psel, input bit per,
                         input int load, input int nmax);
        int div;
        int v;
        div = (psel == 2'b00) ? 1 : (psel == 2'b01) ? 16 : 256;
        setup(16'(load));
        wr(2'd2, 16'h0011 | (16'(psel) << 2) | (per ? 16'h2 : 16'h0));
        for (int n = 1; n <= nmax; n++) begin
            int t;
            int ev;
            int ei;
            @(negedge clk);
            t  = n / div;
            ev = per ? (load - (t % (load + 1))) : ((load - t) & 16'hFFFF);
            ei = (load > 0 && t >= load) ? 1 : 0;
            rd(2'd1, v);
            chk(req, v, ev);
            chk({req, " irq R7"}, int'(irq_o), ei);
        end
    endtask

    initial begin
        int v;
        reg_we = 1'b0; reg_addr = 2'd1; reg_wdata = 16'h0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd1, v); chk("R1 count", v, 0);
        rd(2'd0, v); chk("R1 reload", v, 0);
        rd(2'd2, v); chk("R1 ctrl", v, 16'h0010);
        chk("R1 irq", int'(irq_o), 0);

        // R3 control readback and acknowledge address reads zero (R8)
        wr(2'd2, 16'h000C);
        rd(2'd2, v); chk("R3 ctrl readback", v, 16'h000C);
        rd(2'd3, v); chk("R8 ack reads 0", v, 0);

        sweep("R3 R5 div1 periodic L3", 2'b00, 1'b1, 3, 12);
        sweep("R5 div1 periodic L0", 2'b00, 1'b1, 0, 4);
        sweep("R6 div1 free L2", 2'b00, 1'b0, 2, 6);
        sweep("R4 R5 div16 periodic L2", 2'b01, 1'b1, 2, 64);
        sweep("R4 div256 periodic L1", 2'b10, 1'b1, 1, 600);
        sweep("R4 R6 sel11 free L1", 2'b11, 1'b0, 1, 600);

        // R2 reload write while running takes effect at once
        setup(16'd5);
        wr(2'd2, 16'h0013);
        @(negedge clk); @(negedge clk);
        rd(2'd1, v); chk("R3 running", v, 3);
        wr(2'd0, 16'd9);
        rd(2'd1, v); chk("R2 load while running", v, 9);
        @(negedge clk);
        rd(2'd1, v); chk("R2 step after load", v, 8);

        // R10 writing zero to control stops the count
        wr(2'd2, 16'h0000);
        rd(2'd1, v); chk("R10 stop", v, 7);
        repeat (20) @(negedge clk);
        rd(2'd1, v); chk("R10 hold", v, 7);
        // R2/R10 load while stopped, then enable starts from new value
        wr(2'd0, 16'd4);
        repeat (5) @(negedge clk);
        rd(2'd1, v); chk("R2 load while stopped", v, 4);
        wr(2'd2, 16'h0013);
        rd(2'd1, v); chk("R4 first step one period later", v, 4);
        @(negedge clk);
        rd(2'd1, v); chk("R2 starts from new load", v, 3);

        // R8 acknowledge on the same edge as an expiry: flag survives
        setup(16'd1);
        wr(2'd2, 16'h0013);
        wr(2'd3, 16'h0000);
        chk("R8 set wins over ack", int'(irq_o), 1);
        wr(2'd2, 16'h0010);
        chk("R8 flag pending after stop", int'(irq_o), 1);
        wr(2'd3, 16'hFFFF);
        chk("R8 ack clears", int'(irq_o), 0);
        repeat (3) @(negedge clk);
        chk("R7 no new expiry while stopped", int'(irq_o), 0);

        // R9 masking hides but keeps the flag
        setup(16'd1);
        wr(2'd2, 16'h0003);
        repeat (3) @(negedge clk);
        chk("R9 masked", int'(irq_o), 0);
        wr(2'd2, 16'h0013);
        chk("R9 unmasked shows flag", int'(irq_o), 1);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule